// File: doc/BRIEF.md
# Energy-Detect Power State Controller

This block decides whether a network port runs at full power or sits in a low power state. In energy-detect mode it watches a line-energy flag from the analog front end. When the line has been quiet without a break for a programmed number of coarse sleep units, the port enters low power. It returns to full power once energy has been present without a break for a programmed number of finer wake units. In soft power-down mode the line is ignored, and only the host can bring the port back up.

The host reaches the block through a simple register port. One register holds the two timing fields. A second register gives a one-shot reset pulse to the PHY. A status register reports the power state, and a host read of it is a wake event. The length of each time unit, in clock cycles, is a parameter. A bench can therefore shrink 16 ms and 1 s units to a few cycles.

Top module: `energy_power_ctl`

## Requirements
- R1: A synchronous active-high `rst` forces full power: `low_power`=0 and `phy_reset`=0 on the next edge, and the timing register reads 0x080C (wake field 0x08 in bits 15:8, sleep field 0x0C in bits 7:0). This holds both at start-up and during operation.
- R2: A host write to `TIM_ADDR` loads the timing register, and a read with `host_addr`=`TIM_ADDR` returns it on `host_rdata` in the same cycle. Bits 15:8 give the wake time in units of `WAKE_UNIT_CYCLES` clocks. Bits 7:0 give the sleep time in units of `SLEEP_UNIT_CYCLES` clocks.
- R3: A write of zero to either 8-bit time field leaves that field unchanged. The other field is still written.
- R4: In energy-detect mode (`pwr_mode`=2'b01) at full power, `low_power` rises on the edge that follows sleep_time×`SLEEP_UNIT_CYCLES` consecutive cycles with `line_energy`=0. Any cycle with `line_energy`=1 restarts the count.
- R5: In energy-detect mode at low power, `low_power` falls on the edge that follows wake_time×`WAKE_UNIT_CYCLES` consecutive cycles with `line_energy`=1. A cycle without energy restarts the count.
- R6: Reading `STAT_ADDR` (`host_rd`=1) returns `low_power` in bit 0 and zeros in the other bits. A read while at low power brings `low_power` to 0 on the next edge. A read at full power changes nothing.
- R7: When `pwr_mode` changes to 2'b10 (soft power-down), `low_power` rises on the next edge. While in that mode, `line_energy` has no effect, and only a status read returns the port to full power.
- R8: With `pwr_mode` 2'b00 (normal) or 2'b11 (power saving), `low_power` is 0 from the next edge on, whatever `line_energy` does.
- R9: A write to `PHY_ADDR` with bit 0 = 1 makes `phy_reset` high for exactly the one cycle after the write edge. A write with bit 0 = 0 gives no pulse. A read of `PHY_ADDR` returns 0.
- R10: When the wake count expires in the same cycle as a status read, the port leaves low power once and stays at full power. A sleep count that starts afterwards runs its full length from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode | input | 2 | 00 normal, 01 energy detect, 10 soft power-down, 11 power saving |
| line_energy | input | 1 | High while energy is present on the line |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr`, combinational |
| low_power | output | 1 | High while in the low power state |
| phy_reset | output | 1 | One-cycle PHY reset pulse |

## Verification
The two wake sources can act in the same cycle: the wake timer can expire on the very cycle that the host reads the status register. The bench holds line energy for exactly the wake period and issues the status read on the cycle in which the count is complete. It then requires `low_power` to fall on the next edge and stay low. It also requires that a following quiet spell takes the full sleep period, counted from zero, before the port goes back to low power.

// File: rtl/edpc_pkg.sv
package edpc_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL    = 2'b00,
      PM_ENERGY    = 2'b01,
      PM_SOFT_DOWN = 2'b10,
      PM_SAVING    = 2'b11
   } pmode_e;

   typedef enum logic {
      PS_AWAKE = 1'b0,
      PS_DOZE  = 1'b1
   } pstate_e;

   localparam int NUM_FIELDS = 2;
   localparam int FLD_SLEEP  = 0;
   localparam int FLD_WAKE   = 1;

endpackage

// File: rtl/edpc_run_timer.sv
module edpc_run_timer #(
   parameter int UNIT_CYCLES = 4,
   parameter int LIM_W       = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             arm,
   input  logic [LIM_W-1:0] limit,
   output logic             expired
);

   logic             unit_tick;
   logic [LIM_W-1:0] units_q;

   generate
      if (UNIT_CYCLES < 1) begin : g_bad_unit
         $error("edpc_run_timer: UNIT_CYCLES must be at least 1");
      end
      if (UNIT_CYCLES == 1) begin : g_direct
         assign unit_tick = arm;
      end else begin : g_sub
         localparam int SUB_W = $clog2(UNIT_CYCLES);
         localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_CYCLES - 1);
         logic [SUB_W-1:0] sub_q;

         always_ff @(posedge clk) begin
            if (rst || !arm) begin
               sub_q <= '0;
            end else if (sub_q == SUB_LAST) begin
               sub_q <= '0;
            end else begin
               sub_q <= sub_q + 1'b1;
            end
         end

         assign unit_tick = arm && (sub_q == SUB_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !arm) begin
         units_q <= '0;
      end else if (unit_tick && (units_q < limit)) begin
         units_q <= units_q + 1'b1;
      end
   end

   assign expired = arm && (units_q >= limit);

   // R4 / R5: an expiry can only follow a run that was already armed
   assert_run_unbroken_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(expired) |-> $past(arm));

endmodule

// File: rtl/edpc_regs.sv
module edpc_regs #(
   parameter int              ADDR_W    = 8,
   parameter int              FIELD_W   = 8,
   parameter int              DATA_W    = 16,
   parameter logic [7:0]      WAKE_RST  = 8'h08,
   parameter logic [7:0]      SLEEP_RST = 8'h0C,
   parameter logic [ADDR_W-1:0] TIM_ADDR  = 8'h40,
   parameter logic [ADDR_W-1:0] PHY_ADDR  = 8'h42,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   input  logic               low_power,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [FIELD_W-1:0] wake_lim,
   output logic [FIELD_W-1:0] sleep_lim,
   output logic               stat_read,
   output logic               phy_reset
);
   import edpc_pkg::*;

   logic [DATA_W-1:0] timing_q;
   logic              tim_wr;
   logic              phy_wr;
   logic              phy_pulse_q;

   assign tim_wr    = host_wr && (host_addr == TIM_ADDR);
   assign phy_wr    = host_wr && (host_addr == PHY_ADDR);
   assign stat_read = host_rd && (host_addr == STAT_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         timing_q <= DATA_W'({WAKE_RST, SLEEP_RST});
      end else if (tim_wr) begin
         for (int f = 0; f < NUM_FIELDS; f++) begin
            if (host_wdata[f*FIELD_W +: FIELD_W] != '0) begin
               timing_q[f*FIELD_W +: FIELD_W] <= host_wdata[f*FIELD_W +: FIELD_W];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phy_pulse_q <= 1'b0;
      end else begin
         phy_pulse_q <= phy_wr && host_wdata[0];
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == TIM_ADDR) begin
         host_rdata = timing_q;
      end else if (host_addr == STAT_ADDR) begin
         host_rdata[0] = low_power;
      end
   end

   assign wake_lim  = timing_q[FLD_WAKE*FIELD_W +: FIELD_W];
   assign sleep_lim = timing_q[FLD_SLEEP*FIELD_W +: FIELD_W];
   assign phy_reset = phy_pulse_q;

   assert_zero_wake_kept_R3: assert property (@(posedge clk) disable iff (rst)
      (tim_wr && (host_wdata[FLD_WAKE*FIELD_W +: FIELD_W] == '0)) |=> $stable(wake_lim));

   assert_zero_sleep_kept_R3: assert property (@(posedge clk) disable iff (rst)
      (tim_wr && (host_wdata[FLD_SLEEP*FIELD_W +: FIELD_W] == '0)) |=> $stable(sleep_lim));

   assert_tim_load_R2: assert property (@(posedge clk) disable iff (rst)
      (tim_wr && (host_wdata[FLD_WAKE*FIELD_W +: FIELD_W] != '0))
      |=> (wake_lim == $past(host_wdata[FLD_WAKE*FIELD_W +: FIELD_W])));

   assert_phy_one_shot_R9: assert property (@(posedge clk) disable iff (rst)
      phy_reset |-> $past(host_wr && (host_addr == PHY_ADDR) && host_wdata[0]));

endmodule

// File: rtl/edpc_power_fsm.sv
module edpc_power_fsm (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] pwr_mode,
   input  logic       line_energy,
   input  logic       stat_read,
   input  logic       sleep_exp,
   input  logic       wake_exp,
   output logic       sleep_arm,
   output logic       wake_arm,
   output logic       low_power
);
   import edpc_pkg::*;

   pmode_e  mode_c;
   pmode_e  mode_q;
   pstate_e state_q;
   pstate_e state_d;
   logic    soft_entry;
   logic    full_power_mode;

   assign mode_c          = pmode_e'(pwr_mode);
   assign soft_entry      = (mode_c == PM_SOFT_DOWN) && (mode_q != PM_SOFT_DOWN);
   assign full_power_mode = (mode_c == PM_NORMAL) || (mode_c == PM_SAVING);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_AWAKE: begin
            if (soft_entry) begin
               state_d = PS_DOZE;
            end else if ((mode_c == PM_ENERGY) && sleep_exp) begin
               state_d = PS_DOZE;
            end
         end
         PS_DOZE: begin
            if (full_power_mode || stat_read) begin
               state_d = PS_AWAKE;
            end else if ((mode_c == PM_ENERGY) && wake_exp) begin
               state_d = PS_AWAKE;
            end
         end
         default: state_d = PS_AWAKE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_AWAKE;
         mode_q  <= PM_NORMAL;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_c;
      end
   end

   assign sleep_arm = (state_q == PS_AWAKE) && (mode_c == PM_ENERGY) && !line_energy;
   assign wake_arm  = (state_q == PS_DOZE)  && (mode_c == PM_ENERGY) &&  line_energy;
   assign low_power = (state_q == PS_DOZE);

   assert_soft_ignores_line_R7: assert property (@(posedge clk) disable iff (rst)
      (low_power && (pwr_mode == 2'b10) && !stat_read) |=> low_power);

   assert_full_power_modes_R8: assert property (@(posedge clk) disable iff (rst)
      ((pwr_mode == 2'b00) || (pwr_mode == 2'b11)) |=> !low_power);

   assert_stat_read_wakes_R6: assert property (@(posedge clk) disable iff (rst)
      (low_power && stat_read) |=> !low_power);

   assert_sleep_cause_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(low_power) |-> ($past(pwr_mode == 2'b10) || $past(sleep_exp)));

endmodule

// File: rtl/energy_power_ctl.sv
module energy_power_ctl #(
   parameter int                ADDR_W            = 8,
   parameter int                DATA_W            = 16,
   parameter int                FIELD_W           = 8,
   parameter int                WAKE_UNIT_CYCLES  = 800_000,
   parameter int                SLEEP_UNIT_CYCLES = 50_000_000,
   parameter logic [7:0]        WAKE_RST          = 8'h08,
   parameter logic [7:0]        SLEEP_RST         = 8'h0C,
   parameter logic [ADDR_W-1:0] TIM_ADDR          = 8'h40,
   parameter logic [ADDR_W-1:0] PHY_ADDR          = 8'h42,
   parameter logic [ADDR_W-1:0] STAT_ADDR         = 8'h10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        pwr_mode,
   input  logic              line_energy,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              low_power,
   output logic              phy_reset
);

   generate
      if (DATA_W != 2 * FIELD_W) begin : g_bad_width
         $error("energy_power_ctl: DATA_W must hold exactly two time fields");
      end
      if ((WAKE_RST == '0) || (SLEEP_RST == '0)) begin : g_bad_reset
         $error("energy_power_ctl: time field reset values must be non-zero");
      end
      if ((TIM_ADDR == PHY_ADDR) || (TIM_ADDR == STAT_ADDR) || (PHY_ADDR == STAT_ADDR)) begin : g_bad_map
         $error("energy_power_ctl: register addresses must differ");
      end
   endgenerate

   logic [FIELD_W-1:0] wake_lim;
   logic [FIELD_W-1:0] sleep_lim;
   logic               stat_read;
   logic               sleep_arm;
   logic               wake_arm;
   logic               sleep_exp;
   logic               wake_exp;

   edpc_regs #(
      .ADDR_W    (ADDR_W),
      .FIELD_W   (FIELD_W),
      .DATA_W    (DATA_W),
      .WAKE_RST  (WAKE_RST),
      .SLEEP_RST (SLEEP_RST),
      .TIM_ADDR  (TIM_ADDR),
      .PHY_ADDR  (PHY_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_regs (
      .clk        (clk),
      .rst        (rst),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .low_power  (low_power),
      .host_rdata (host_rdata),
      .wake_lim   (wake_lim),
      .sleep_lim  (sleep_lim),
      .stat_read  (stat_read),
      .phy_reset  (phy_reset)
   );

   edpc_run_timer #(
      .UNIT_CYCLES (SLEEP_UNIT_CYCLES),
      .LIM_W       (FIELD_W)
   ) u_sleep_timer (
      .clk     (clk),
      .rst     (rst),
      .arm     (sleep_arm),
      .limit   (sleep_lim),
      .expired (sleep_exp)
   );

   edpc_run_timer #(
      .UNIT_CYCLES (WAKE_UNIT_CYCLES),
      .LIM_W       (FIELD_W)
   ) u_wake_timer (
      .clk     (clk),
      .rst     (rst),
      .arm     (wake_arm),
      .limit   (wake_lim),
      .expired (wake_exp)
   );

   edpc_power_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .pwr_mode    (pwr_mode),
      .line_energy (line_energy),
      .stat_read   (stat_read),
      .sleep_exp   (sleep_exp),
      .wake_exp    (wake_exp),
      .sleep_arm   (sleep_arm),
      .wake_arm    (wake_arm),
      .low_power   (low_power)
   );

   // R10: both wake sources together still give a single exit
   assert_joint_wake_R10: assert property (@(posedge clk) disable iff (rst)
      (low_power && stat_read && wake_exp) |=> !low_power);

endmodule

// File: tb/energy_power_ctl_bench.sv
module energy_power_ctl_bench;

   localparam int WU = 3;
   localparam int SU = 5;
   localparam logic [7:0] A_TIM  = 8'h40;
   localparam logic [7:0] A_PHY  = 8'h42;
   localparam logic [7:0] A_STAT = 8'h10;
   localparam int K_LOW = 0;
   localparam int K_PHY = 1;
   localparam int K_RD  = 2;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  mode;
   logic        energy;
   logic [7:0]  addr;
   logic        wr;
   logic        rd;
   logic [15:0] wdata;
   logic [15:0] rdata;
   logic        lowp;
   logic        phyr;

   always #10 clk = ~clk;

   energy_power_ctl #(
      .WAKE_UNIT_CYCLES  (WU),
      .SLEEP_UNIT_CYCLES (SU),
      .TIM_ADDR          (A_TIM),
      .PHY_ADDR          (A_PHY),
      .STAT_ADDR         (A_STAT)
   ) u_energy_power_ctl (
      .clk         (clk),
      .rst         (rst),
      .pwr_mode    (mode),
      .line_energy (energy),
      .host_addr   (addr),
      .host_wr     (wr),
      .host_rd     (rd),
      .host_wdata  (wdata),
      .host_rdata  (rdata),
      .low_power   (lowp),
      .phy_reset   (phyr)
   );

   typedef struct {
      int    at;
      int    kind;
      int    val;
      string req;
   } exp_t;

   exp_t q[$];
   int   cyc   = 0;
   int   total = 0;
   int   bad   = 0;
   bit   over  = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(int dly, int kind, int val, string req);
      exp_t e;
      int   pos;
      e.at = cyc + dly; e.kind = kind; e.val = val; e.req = req;
      pos = q.size();
      for (int i = 0; i < q.size(); i++) begin
         if (q[i].at > e.at) begin
            pos = i;
            break;
         end
      end
      q.insert(pos, e);
   endtask

   // monitor: pops every expectation due in this cycle
   always @(negedge clk) begin
      exp_t e;
      int   act;
      while (q.size() > 0 && q[0].at <= cyc) begin
         e = q.pop_front();
         case (e.kind)
            K_LOW:   act = int'(lowp);
            K_PHY:   act = int'(phyr);
            default: act = int'(rdata);
         endcase
         total++;
         if (act != e.val) begin
            bad++;
            $display("FAIL %s cycle %0d kind %0d: actual=0x%0h expected=0x%0h",
                     e.req, cyc, e.kind, act, e.val);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic host_write(logic [7:0] a, logic [15:0] d);
      wr = 1'b1; addr = a; wdata = d;
      step(1);
      wr = 1'b0;
   endtask

   task automatic peek(logic [7:0] a, int val, string req);
      addr = a;
      expect_at(0, K_RD, val, req);
   endtask

   task automatic status_read(int val_before);
      rd = 1'b1; addr = A_STAT;
      expect_at(0, K_RD, val_before, "R6");
      step(1);
      rd = 1'b0;
   endtask

   initial begin
      rst = 1'b1; mode = 2'b00; energy = 1'b1; addr = A_TIM;
      wr = 1'b0; rd = 1'b0; wdata = '0;
      step(3);
      rst = 1'b0;
      // R1: reset state
      expect_at(0, K_LOW, 0, "R1");
      expect_at(0, K_PHY, 0, "R1");
      peek(A_TIM, 16'h080C, "R1");
      step(1);

      // R8: normal mode never sleeps
      energy = 1'b0;
      step(80);
      expect_at(0, K_LOW, 0, "R8");
      step(1);

      // R2 / R3: timing register
      host_write(A_TIM, 16'h0203);
      peek(A_TIM, 16'h0203, "R2");
      step(1);
      host_write(A_TIM, 16'h0000);
      peek(A_TIM, 16'h0203, "R3");
      step(1);
      host_write(A_TIM, 16'h0500);
      peek(A_TIM, 16'h0503, "R3");
      step(1);
      host_write(A_TIM, 16'h0002);
      peek(A_TIM, 16'h0502, "R3");
      step(1);
      host_write(A_TIM, 16'h0203);

      // R4: energy-detect sleep with a restart in the middle
      energy = 1'b1; mode = 2'b01;
      step(2);
      energy = 1'b0;
      step(10);
      expect_at(0, K_LOW, 0, "R4");
      energy = 1'b1;
      step(1);
      energy = 1'b0;
      expect_at(15, K_LOW, 0, "R4");
      expect_at(16, K_LOW, 1, "R4");
      step(17);

      // R5: interrupted wake, then full wake
      energy = 1'b1;
      step(4);
      energy = 1'b0;
      step(5);
      expect_at(0, K_LOW, 1, "R5");
      energy = 1'b1;
      expect_at(6, K_LOW, 1, "R5");
      expect_at(7, K_LOW, 0, "R5");
      step(8);

      // R6: status read wakes from energy-detect low power
      energy = 1'b0;
      step(17);
      expect_at(0, K_LOW, 1, "R6");
      energy = 1'b1;
      status_read(1);
      expect_at(0, K_LOW, 0, "R6");
      step(1);
      status_read(0);
      expect_at(0, K_LOW, 0, "R6");
      step(1);

      // R10: wake timer expiry and status read in one cycle
      energy = 1'b0;
      step(17);
      expect_at(0, K_LOW, 1, "R10");
      energy = 1'b1;
      step(6);
      status_read(1);
      expect_at(0, K_LOW, 0, "R10");
      expect_at(3, K_LOW, 0, "R10");
      energy = 1'b0;
      expect_at(15, K_LOW, 0, "R10");
      expect_at(16, K_LOW, 1, "R10");
      step(17);
      energy = 1'b1;
      status_read(1);

      // R7: soft power-down
      mode = 2'b10;
      expect_at(1, K_LOW, 1, "R7");
      step(2);
      step(30);
      expect_at(0, K_LOW, 1, "R7");
      energy = 1'b0;
      step(5);
      energy = 1'b1;
      step(10);
      expect_at(0, K_LOW, 1, "R7");
      status_read(1);
      expect_at(0, K_LOW, 0, "R7");
      step(10);
      expect_at(0, K_LOW, 0, "R7");

      // R8: leaving soft power-down through power-saving mode
      mode = 2'b00;
      step(1);
      mode = 2'b10;
      expect_at(1, K_LOW, 1, "R7");
      step(2);
      mode = 2'b11;
      expect_at(1, K_LOW, 0, "R8");
      energy = 1'b0;
      step(60);
      expect_at(0, K_LOW, 0, "R8");
      energy = 1'b1;

      // R9: PHY reset pulse
      host_write(A_PHY, 16'h0001);
      expect_at(0, K_PHY, 1, "R9");
      expect_at(1, K_PHY, 0, "R9");
      step(2);
      host_write(A_PHY, 16'hFFFE);
      expect_at(0, K_PHY, 0, "R9");
      expect_at(1, K_PHY, 0, "R9");
      peek(A_PHY, 0, "R9");
      step(2);

      // R1: reset during low power
      mode = 2'b00;
      step(1);
      mode = 2'b10;
      step(2);
      expect_at(0, K_LOW, 1, "R7");
      rst = 1'b1; mode = 2'b00;
      step(1);
      rst = 1'b0;
      expect_at(0, K_LOW, 0, "R1");
      peek(A_TIM, 16'h080C, "R1");
      step(3);

      while (q.size() > 0) step(1);
      over = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!over) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule